// File: doc/BRIEF.md
# SD Host Command Register Front-End

This block is the register face of an SD/MMC host controller. Software writes a command index, a 32-bit argument, a response type and a command-type nibble, plus the block length and block count of a data transfer. Writing the control byte with its start bit set hands the command to a separate bus engine. That engine is modelled here only as a busy input, single-cycle event strobes and a byte-wide response write port.

Completion and error strobes from the engine are latched into status bytes. Each status bit is cleared by writing a 1 to it. A mask register with the same bit layout sits beside each status byte, and together the masked status bits drive one interrupt line. The engine stores the 16 response bytes in a buffer whose byte order is rotated by one position, so a driver that reads words from fixed offsets sees the layout it expects.

Register map (byte addresses): control 0x00, command index 0x01, response type 0x02, bus mode 0x03, argument 0x04–0x07 (least significant byte first), block length 0x08–0x09, block count 0x0A–0x0B, mask 0 at 0x0C, mask 1 at 0x0D, status bytes 0x10–0x13, response buffer 0x20–0x2F. Reads have no side effects, and `reg_rdata` follows `reg_addr` combinationally.

Top module: `sdhost_cmd_regs`

## Requirements
- R1: A write to control with bit0 = 1 while the engine is idle raises `eng_start` for exactly the one cycle after the write clock edge. Control bit0 then reads back 0.
- R2: A start write made while `eng_busy` = 1, or while a start pulse is already present, produces no `eng_start` pulse.
- R3: Control bits 7:4 appear on `eng_cmd_type` and bit2 appears on `eng_write`. The type codes are: 0 no data, 1 single-block write, 2 single-block read, 3 multi-block write, 4 multi-block read, 7 stop transmission.
- R4: The four argument bytes form `eng_arg`, with the byte at 0x04 as the least significant byte. The command index and the response type (9 = busy-signalling R1b, 2 = ordinary short response) are passed to the engine unchanged.
- R5: Engine strobes set status byte 1 (0x11) bits as follows: bit1 done, bit2 response timeout, bit3 auto-stop done, bit4 data timeout, bit5 response CRC error, bit6 read CRC error, bit7 write CRC error. Each bit stays set until it is cleared.
- R6: Writing a status byte clears the bits written as 1 and leaves the bits written as 0. Writing 0xFF clears the whole byte. An event that arrives in the same cycle as a clear leaves its bit set. Status bytes 2 and 3 read 0.
- R7: Status byte 0 (0x10) latches device-insert in bit7 and card-detect change in bit6.
- R8: `irq` is 1 exactly when block-length bit15 is 1 and some status bit in byte 0 or byte 1 is set while the mask bit at the same position (0x0C, 0x0D) is also set.
- R9: Engine response byte n = 4k + j (word k, byte j) is stored at buffer offset (n + 1) mod 16. Byte 15 is therefore read at offset 0.
- R10: Writing control bit3 = 1 clears the whole response buffer at that edge, and the bit always reads back 0. A clear takes priority over an engine response write in the same cycle.
- R11: Block-length bits 10:0 (block size minus one) drive `eng_blk_len` and bit13 drives `cd_gpi_sel`. The 16-bit block count drives `eng_blk_cnt`.
- R12: Bus-mode bit1 drives `bus_4bit`, bit2 drives `bus_8bit` and bit4 drives `card_pwr_off`. Writing bit7 = 1 returns every register, status bit and response byte to 0.
- R13: After reset every register reads 0, and `irq` and `eng_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| eng_start | output | 1 | One-cycle command launch |
| eng_cmd_idx | output | 8 | Command index |
| eng_arg | output | 32 | Command argument |
| eng_rsp_type | output | 8 | Response type code |
| eng_cmd_type | output | 4 | Command type nibble |
| eng_write | output | 1 | Data direction, 1 = write to card |
| eng_blk_len | output | 11 | Block size minus one |
| eng_blk_cnt | output | 16 | Block count |
| eng_busy | input | 1 | Engine is executing a command |
| ev_cmd_done | input | 1 | Command/response done strobe |
| ev_rsp_tmo | input | 1 | Response timeout strobe |
| ev_autostop | input | 1 | Auto-stop done strobe |
| ev_data_tmo | input | 1 | Data timeout strobe |
| ev_rsp_crc | input | 1 | Response CRC error strobe |
| ev_rd_crc | input | 1 | Read-data CRC error strobe |
| ev_wr_crc | input | 1 | Write-data CRC error strobe |
| ev_card_det | input | 1 | Card-detect change strobe |
| ev_dev_ins | input | 1 | Device-inserted strobe |
| rsp_we | input | 1 | Response byte write |
| rsp_idx | input | 4 | Logical response byte index |
| rsp_byte | input | 8 | Response byte value |
| bus_4bit | output | 1 | 4-bit bus mode |
| bus_8bit | output | 1 | 8-bit bus mode |
| card_pwr_off | output | 1 | Card power off |
| cd_gpi_sel | output | 1 | Use the general-purpose pin for card detect |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that event strobes, register writes and response writes are held stable across a clock edge. They also assume that a soft-reset write is the only way every register is forced to zero at once, so the properties for event set and write-one-to-clear are excused in the cycle of a soft reset. The stimulus changes every input only on the falling edge. It overlaps an event strobe with a clear of the same bit, raises `eng_busy` across a start write, and issues a soft reset only once, at the end, after all other behaviour has been exercised.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
    localparam int ADDR_W = 6;
    localparam int N_STS  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] A_CIDX  = 6'h01;
    localparam logic [ADDR_W-1:0] A_RTYPE = 6'h02;
    localparam logic [ADDR_W-1:0] A_BUSM  = 6'h03;
    localparam logic [ADDR_W-1:0] A_ARG0  = 6'h04;
    localparam logic [ADDR_W-1:0] A_BLKL0 = 6'h08;
    localparam logic [ADDR_W-1:0] A_BLKC0 = 6'h0A;
    localparam logic [ADDR_W-1:0] A_MASK0 = 6'h0C;
    localparam logic [ADDR_W-1:0] A_STS0  = 6'h10;
    localparam logic [ADDR_W-1:0] A_RSP   = 6'h20;

    localparam int CB_START = 0;
    localparam int CB_WDIR  = 2;
    localparam int CB_FCLR  = 3;
    localparam int BM_SRST  = 7;
    localparam int BL_IEN   = 15;
    localparam int BL_GPI   = 13;

    typedef struct packed {
        logic [3:0]  ctype;
        logic        wdir;
        logic        start;
        logic [7:0]  cidx;
        logic [7:0]  rtype;
        logic [7:0]  busm;
        logic [31:0] arg;
        logic [15:0] blkl;
        logic [15:0] blkc;
        logic [7:0]  mask0;
        logic [7:0]  mask1;
    } cfg_t;
endpackage

// File: rtl/sdh_w1c_byte.sv
module sdh_w1c_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         kill_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (wr_i) q_d = q_d & ~wdata_i;
        q_d = q_d | set_i;
        if (kill_i) q_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

    // R5 / R6: a strobed event is visible on the next cycle, even against a clear
    p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_i) && !kill_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R6: bits written as one with no event go low
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !kill_i) |=> ((q_o & $past(wdata_i & ~set_i)) == '0));
endmodule

// File: rtl/sdh_rsp_buf.sv
module sdh_rsp_buf #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [7:0]    wbyte_i,
    input  logic [IW-1:0] raddr_i,
    output logic [7:0]    rbyte_o
);
    logic [N-1:0][7:0] mem_d, mem_q;
    logic [IW-1:0]     slot;

    always_comb begin
        slot  = widx_i + IW'(1);
        mem_d = mem_q;
        if (we_i) mem_d[slot] = wbyte_i;
        if (clr_i) mem_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rbyte_o = mem_q[raddr_i];

    // R10: a clear empties every byte on the following cycle
    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mem_q == '0));

    // R9: the byte written lands one slot ahead of its logical index
    p_rotated_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clr_i) |=> (mem_q[$past(widx_i) + IW'(1)] == $past(wbyte_i)));
endmodule

// File: rtl/sdhost_cmd_regs.sv
module sdhost_cmd_regs
    import sdh_pkg::*;
#(
    parameter int RSP_BYTES = 16,
    parameter int BLEN_W    = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [5:0]                    reg_addr,
    input  logic [7:0]                    reg_wdata,
    output logic [7:0]                    reg_rdata,
    output logic                          eng_start,
    output logic [7:0]                    eng_cmd_idx,
    output logic [31:0]                   eng_arg,
    output logic [7:0]                    eng_rsp_type,
    output logic [3:0]                    eng_cmd_type,
    output logic                          eng_write,
    output logic [BLEN_W-1:0]             eng_blk_len,
    output logic [15:0]                   eng_blk_cnt,
    input  logic                          eng_busy,
    input  logic                          ev_cmd_done,
    input  logic                          ev_rsp_tmo,
    input  logic                          ev_autostop,
    input  logic                          ev_data_tmo,
    input  logic                          ev_rsp_crc,
    input  logic                          ev_rd_crc,
    input  logic                          ev_wr_crc,
    input  logic                          ev_card_det,
    input  logic                          ev_dev_ins,
    input  logic                          rsp_we,
    input  logic [$clog2(RSP_BYTES)-1:0]  rsp_idx,
    input  logic [7:0]                    rsp_byte,
    output logic                          bus_4bit,
    output logic                          bus_8bit,
    output logic                          card_pwr_off,
    output logic                          cd_gpi_sel,
    output logic                          irq
);
    localparam int RSP_IW = $clog2(RSP_BYTES);

    cfg_t cfg_d, cfg_q;
    logic soft_rst, fifo_clr, in_rsp;
    logic [7:0] sts_set [N_STS];
    logic [7:0] sts_q   [N_STS];
    logic [7:0] mask    [N_STS];
    logic [7:0] rsp_rd;
    logic [N_STS-1:0] pend;

    assign soft_rst = reg_wr && (reg_addr == A_BUSM) && reg_wdata[BM_SRST];
    assign fifo_clr = (reg_wr && (reg_addr == A_CTRL) && reg_wdata[CB_FCLR]) || soft_rst;
    assign in_rsp   = (reg_addr[ADDR_W-1:RSP_IW] == A_RSP[ADDR_W-1:RSP_IW]);

    always_comb begin
        cfg_d       = cfg_q;
        cfg_d.start = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    cfg_d.ctype = reg_wdata[7:4];
                    cfg_d.wdir  = reg_wdata[CB_WDIR];
                    cfg_d.start = reg_wdata[CB_START] && !eng_busy && !cfg_q.start;
                end
                A_CIDX:  cfg_d.cidx  = reg_wdata;
                A_RTYPE: cfg_d.rtype = reg_wdata;
                A_BUSM:  cfg_d.busm  = reg_wdata & 8'h7F;
                A_MASK0: cfg_d.mask0 = reg_wdata;
                A_MASK0 + 6'd1: cfg_d.mask1 = reg_wdata;
                default: ;
            endcase
            if (reg_addr[ADDR_W-1:2] == A_ARG0[ADDR_W-1:2])
                cfg_d.arg[8*int'(reg_addr[1:0]) +: 8] = reg_wdata;
            if (reg_addr[ADDR_W-1:1] == A_BLKL0[ADDR_W-1:1]) begin
                if (reg_addr[0]) cfg_d.blkl[15:8] = reg_wdata;
                else             cfg_d.blkl[7:0]  = reg_wdata;
            end
            if (reg_addr[ADDR_W-1:1] == A_BLKC0[ADDR_W-1:1]) begin
                if (reg_addr[0]) cfg_d.blkc[15:8] = reg_wdata;
                else             cfg_d.blkc[7:0]  = reg_wdata;
            end
        end
        if (soft_rst) cfg_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sts_set[0] = {ev_dev_ins, ev_card_det, 6'b0};
    assign sts_set[1] = {ev_wr_crc, ev_rd_crc, ev_rsp_crc, ev_data_tmo,
                         ev_autostop, ev_rsp_tmo, ev_cmd_done, 1'b0};
    assign mask[0] = cfg_q.mask0;
    assign mask[1] = cfg_q.mask1;

    for (genvar g = 0; g < N_STS; g++) begin : g_sts
        sdh_w1c_byte #(.W(8)) i_sts (
            .clk     (clk),
            .rst_n   (rst_n),
            .kill_i  (soft_rst),
            .wr_i    (reg_wr && (reg_addr == A_STS0 + 6'(g))),
            .wdata_i (reg_wdata),
            .set_i   (sts_set[g]),
            .q_o     (sts_q[g])
        );
        assign pend[g] = |(sts_q[g] & mask[g]);
    end

    sdh_rsp_buf #(.N(RSP_BYTES)) i_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (fifo_clr),
        .we_i    (rsp_we),
        .widx_i  (rsp_idx),
        .wbyte_i (rsp_byte),
        .raddr_i (reg_addr[RSP_IW-1:0]),
        .rbyte_o (rsp_rd)
    );

    always_comb begin
        reg_rdata = 8'h00;
        case (reg_addr)
            A_CTRL:          reg_rdata = {cfg_q.ctype, 1'b0, cfg_q.wdir, 1'b0, cfg_q.start};
            A_CIDX:          reg_rdata = cfg_q.cidx;
            A_RTYPE:         reg_rdata = cfg_q.rtype;
            A_BUSM:          reg_rdata = cfg_q.busm;
            A_ARG0:          reg_rdata = cfg_q.arg[7:0];
            A_ARG0 + 6'd1:   reg_rdata = cfg_q.arg[15:8];
            A_ARG0 + 6'd2:   reg_rdata = cfg_q.arg[23:16];
            A_ARG0 + 6'd3:   reg_rdata = cfg_q.arg[31:24];
            A_BLKL0:         reg_rdata = cfg_q.blkl[7:0];
            A_BLKL0 + 6'd1:  reg_rdata = cfg_q.blkl[15:8];
            A_BLKC0:         reg_rdata = cfg_q.blkc[7:0];
            A_BLKC0 + 6'd1:  reg_rdata = cfg_q.blkc[15:8];
            A_MASK0:         reg_rdata = cfg_q.mask0;
            A_MASK0 + 6'd1:  reg_rdata = cfg_q.mask1;
            A_STS0:          reg_rdata = sts_q[0];
            A_STS0 + 6'd1:   reg_rdata = sts_q[1];
            default:         reg_rdata = in_rsp ? rsp_rd : 8'h00;
        endcase
    end

    assign eng_start    = cfg_q.start;
    assign eng_cmd_idx  = cfg_q.cidx;
    assign eng_arg      = cfg_q.arg;
    assign eng_rsp_type = cfg_q.rtype;
    assign eng_cmd_type = cfg_q.ctype;
    assign eng_write    = cfg_q.wdir;
    assign eng_blk_len  = cfg_q.blkl[BLEN_W-1:0];
    assign eng_blk_cnt  = cfg_q.blkc;
    assign bus_4bit     = cfg_q.busm[1];
    assign bus_8bit     = cfg_q.busm[2];
    assign card_pwr_off = cfg_q.busm[4];
    assign cd_gpi_sel   = cfg_q.blkl[BL_GPI];
    assign irq          = cfg_q.blkl[BL_IEN] && (|pend);

    // R1: a launch lasts one cycle
    p_start_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R2: a start write during a busy engine launches nothing
    p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[CB_START] && eng_busy) |=> !eng_start);

    // R8: no interrupt without the global enable bit
    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg_q.blkl[BL_IEN]);

    // R12: soft reset clears the engine-facing fields and the interrupt
    p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (eng_arg == '0 && !irq && eng_cmd_type == '0 && eng_blk_cnt == '0));
endmodule

// File: tb/test_sdhost_cmd_regs.sv
module test_sdhost_cmd_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic eng_busy = 1'b0;
    logic [7:0] ev0 = '0, ev1 = '0;
    logic rsp_we = 1'b0;
    logic [3:0] rsp_idx = '0;
    logic [7:0] rsp_byte = '0;

    logic [7:0]  reg_rdata, eng_cmd_idx, eng_rsp_type;
    logic        eng_start, eng_write, bus_4bit, bus_8bit, card_pwr_off, cd_gpi_sel, irq;
    logic [31:0] eng_arg;
    logic [3:0]  eng_cmd_type;
    logic [10:0] eng_blk_len;
    logic [15:0] eng_blk_cnt;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sdhost_cmd_regs i_sdhost_cmd_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_cmd_idx(eng_cmd_idx), .eng_arg(eng_arg), .eng_rsp_type(eng_rsp_type),
        .eng_cmd_type(eng_cmd_type), .eng_write(eng_write), .eng_blk_len(eng_blk_len),
        .eng_blk_cnt(eng_blk_cnt), .eng_busy(eng_busy),
        .ev_cmd_done(ev1[1]), .ev_rsp_tmo(ev1[2]), .ev_autostop(ev1[3]),
        .ev_data_tmo(ev1[4]), .ev_rsp_crc(ev1[5]), .ev_rd_crc(ev1[6]),
        .ev_wr_crc(ev1[7]), .ev_card_det(ev0[6]), .ev_dev_ins(ev0[7]),
        .rsp_we(rsp_we), .rsp_idx(rsp_idx), .rsp_byte(rsp_byte),
        .bus_4bit(bus_4bit), .bus_8bit(bus_8bit), .card_pwr_off(card_pwr_off),
        .cd_gpi_sel(cd_gpi_sel), .irq(irq)
    );

    // ---- behavioural reference model ----
    bit [3:0] m_type; bit m_wdir, m_start;
    byte unsigned m_arg[4], m_bl[2], m_bc[2], m_mk[2], m_st[2], m_rsp[16];

    task automatic m_zero();
        m_type = 0; m_wdir = 0; m_start = 0;
        foreach (m_arg[i]) m_arg[i] = 0;
        foreach (m_bl[i]) begin m_bl[i] = 0; m_bc[i] = 0; m_mk[i] = 0; m_st[i] = 0; end
        foreach (m_rsp[i]) m_rsp[i] = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_zero();
        else begin
            byte unsigned nst[2];
            bit nstart;
            nst[0] = m_st[0]; nst[1] = m_st[1];
            for (int i = 0; i < 2; i++)
                if (reg_wr && reg_addr == 6'h10 + 6'(i)) nst[i] = nst[i] & ~reg_wdata;
            nst[0] = nst[0] | (ev0 & 8'hC0);
            nst[1] = nst[1] | (ev1 & 8'hFE);
            m_st[0] = nst[0]; m_st[1] = nst[1];
            nstart = 0;
            if (rsp_we) m_rsp[(int'(rsp_idx) + 1) % 16] = rsp_byte;
            if (reg_wr) begin
                if (reg_addr == 6'h00) begin
                    m_type = reg_wdata[7:4]; m_wdir = reg_wdata[2];
                    nstart = reg_wdata[0] && !eng_busy && !m_start;
                    if (reg_wdata[3]) foreach (m_rsp[i]) m_rsp[i] = 0;
                end
                if (reg_addr >= 6'h04 && reg_addr <= 6'h07) m_arg[reg_addr - 6'h04] = reg_wdata;
                if (reg_addr == 6'h08 || reg_addr == 6'h09) m_bl[reg_addr - 6'h08] = reg_wdata;
                if (reg_addr == 6'h0A || reg_addr == 6'h0B) m_bc[reg_addr - 6'h0A] = reg_wdata;
                if (reg_addr == 6'h0C || reg_addr == 6'h0D) m_mk[reg_addr - 6'h0C] = reg_wdata;
            end
            m_start = nstart;
            if (reg_wr && reg_addr == 6'h03 && reg_wdata[7]) m_zero();
        end
    end

    function automatic bit m_irq();
        return m_bl[1][7] && (((m_st[0] & m_mk[0]) | (m_st[1] & m_mk[1])) != 0);
    endfunction

    task automatic chk(string tag, longint got, longint exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model (R1, R3, R4, R8)
    always @(negedge clk) if (rst_n && !finished) begin
        chk("R1 model start", eng_start, m_start);
        chk("R8 model irq", irq, m_irq());
        chk("R3 model type", eng_cmd_type, m_type);
        chk("R4 model arg", eng_arg, {m_arg[3], m_arg[2], m_arg[1], m_arg[0]});
    end

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, logic [7:0] exp, string tag);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic ev(logic [7:0] v0, logic [7:0] v1);
        @(negedge clk); ev0 = v0; ev1 = v1;
        @(negedge clk); ev0 = 0; ev1 = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        rd(6'h00, 8'h00, "R13 ctrl"); rd(6'h04, 8'h00, "R13 arg");
        rd(6'h09, 8'h00, "R13 blkl"); rd(6'h11, 8'h00, "R13 sts1");
        rd(6'h20, 8'h00, "R13 rsp");  chk("R13 irq", irq, 0);

        // R4 fields
        wr(6'h01, 8'h11); wr(6'h02, 8'h09);
        wr(6'h04, 8'h78); wr(6'h05, 8'h56); wr(6'h06, 8'h34); wr(6'h07, 8'h12);
        chk("R4 arg", eng_arg, 32'h12345678);
        chk("R4 cidx", eng_cmd_idx, 8'h11);
        chk("R4 rtype R1b", eng_rsp_type, 8'h09);

        // R1 / R3 multi-block read launch
        wr(6'h00, 8'h41);
        chk("R1 pulse", eng_start, 1);
        chk("R3 type multi read", eng_cmd_type, 4);
        chk("R3 dir read", eng_write, 0);
        @(negedge clk);
        chk("R1 pulse ends", eng_start, 0);
        rd(6'h00, 8'h40, "R1 self clear");

        // R2 busy blocks start; R3 multi-block write
        eng_busy = 1;
        wr(6'h00, 8'h35);
        chk("R2 no pulse", eng_start, 0);
        chk("R3 type multi write", eng_cmd_type, 3);
        chk("R3 dir write", eng_write, 1);
        eng_busy = 0;
        wr(6'h00, 8'h71);
        chk("R3 stop type", eng_cmd_type, 7);
        chk("R1 stop pulse", eng_start, 1);

        // R5 status byte 1
        ev(8'h00, 8'h06);
        rd(6'h11, 8'h06, "R5 done+rsp tmo");
        ev(8'h00, 8'hF8);
        rd(6'h11, 8'hFE, "R5 all events");

        // R6 write-one-to-clear
        wr(6'h11, 8'h06); rd(6'h11, 8'hF8, "R6 partial clear");
        wr(6'h11, 8'h00); rd(6'h11, 8'hF8, "R6 zero write");
        wr(6'h11, 8'hFF); rd(6'h11, 8'h00, "R6 full clear");
        @(negedge clk); ev1 = 8'h02; reg_wr = 1; reg_addr = 6'h11; reg_wdata = 8'h02;
        @(negedge clk); ev1 = 0; reg_wr = 0;
        rd(6'h11, 8'h02, "R6 event beats clear");
        rd(6'h12, 8'h00, "R6 sts2 zero");

        // R7 status byte 0
        ev(8'hC0, 8'h00);
        rd(6'h10, 8'hC0, "R7 insert+detect");

        // R8 interrupt
        wr(6'h0D, 8'h02);
        chk("R8 enable off", irq, 0);
        wr(6'h09, 8'h80);
        chk("R8 masked pending", irq, 1);
        wr(6'h11, 8'hFF);
        chk("R8 cleared", irq, 0);
        wr(6'h0C, 8'h80);
        chk("R8 byte0 insert", irq, 1);
        wr(6'h10, 8'h80);
        chk("R8 unmasked bit only", irq, 0);

        // R11 block length and count
        wr(6'h08, 8'hFF); wr(6'h09, 8'hA1); wr(6'h0A, 8'h03); wr(6'h0B, 8'h02);
        chk("R11 blk len", eng_blk_len, 11'h1FF);
        chk("R11 gpi sel", cd_gpi_sel, 1);
        chk("R11 blk cnt", eng_blk_cnt, 16'h0203);

        // R9 rotated response
        for (int n = 0; n < 16; n++) begin
            @(negedge clk); rsp_we = 1; rsp_idx = 4'(n); rsp_byte = 8'hA0 + 8'(n);
        end
        @(negedge clk); rsp_we = 0;
        for (int o = 0; o < 16; o++)
            rd(6'h20 + 6'(o), 8'hA0 + 8'((o + 15) % 16), "R9 rotation");

        // R10 FIFO reset
        wr(6'h00, 8'h08);
        rd(6'h00, 8'h00, "R10 bit reads 0");
        rd(6'h20, 8'h00, "R10 offset 0 cleared");
        rd(6'h2A, 8'h00, "R10 offset 10 cleared");

        // R12 bus mode and soft reset
        wr(6'h03, 8'h16);
        chk("R12 4bit", bus_4bit, 1); chk("R12 8bit", bus_8bit, 1);
        chk("R12 pwr off", card_pwr_off, 1);
        @(negedge clk); rsp_we = 1; rsp_idx = 4'd3; rsp_byte = 8'h5A;
        @(negedge clk); rsp_we = 0;
        ev(8'h40, 8'h10);
        wr(6'h03, 8'h80);
        rd(6'h03, 8'h00, "R12 busmode");
        rd(6'h04, 8'h00, "R12 arg");
        rd(6'h10, 8'h00, "R12 sts0");
        rd(6'h11, 8'h00, "R12 sts1");
        rd(6'h24, 8'h00, "R12 rsp");
        chk("R12 blk cnt", eng_blk_cnt, 0);
        chk("R12 bus4", bus_4bit, 0);
        chk("R12 irq", irq, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule